// File: doc/BRIEF.md
# NAND Flash Bus Bridge

This block connects a synchronous static-memory bus master to an 8-bit raw NAND flash device. It decodes one fixed address window, 0x4000_0000 to 0x4FFF_FFFF. While a transfer's address lies inside that window, the master's active-low read and write strobes pass straight through as the device's read-enable and write-enable. As soon as the address leaves the window, both device strobes are released in the same cycle. Two address bits choose the kind of bus cycle. Bit 21 raises the command-latch pin and bit 22 raises the address-latch pin. Software therefore sends a command, an address byte or a data byte by writing to a different offset in the window.

The device chip enable does not follow the window decode. It comes from a one-bit register that software writes, and it stays asserted between accesses so that the device never drops to standby in the middle of an operation. The device ready/busy line passes through a two-flop synchronizer. Its synchronized level is shown as status, and a one-cycle pulse marks each busy-to-ready edge. Ready/busy never gates the strobes.

A small state machine tracks the class of the current bus cycle. Its states are `ST_IDLE`, `ST_CMD`, `ST_ADDR`, `ST_WDATA` and `ST_RDATA`. Every clock it moves to the class of the cycle on the bus:
- idle when no strobe is active inside the enabled window;
- command, address or write data for a write, depending on the offset;
- read data for a read.

Leaving `ST_RDATA` is the transition that loads the read-data register.

Top module: `nand_bus_bridge`

## Requirements
- R1: While reset is asserted and right after it, `nand_re_n`, `nand_we_n` and `nand_ce_n` are 1, `nand_cle` and `nand_ale` are 0, and `bus_rdata`, `ill_flag`, `rb_ready` and `rb_rise` are 0.
- R2: An address is in the window when its upper nibble (bits 31:28) equals 4. Inside the window, `nand_we_n` equals `bus_wr_n` and `nand_re_n` equals `bus_rd_n` in the same cycle. Outside the window both are 1 in the same cycle.
- R3: When `cfg_en` is 0, `nand_re_n` and `nand_we_n` are 1 and `nand_cle` and `nand_ale` are 0, whatever the bus does.
- R4: Inside the enabled window, `nand_cle` equals address bit 21 and `nand_ale` equals address bit 22, combinationally. Outside the window both are 0.
- R5: When bits 21 and 22 are both 1, `nand_cle` and `nand_ale` are both 0. If a strobe is also active inside the enabled window, `ill_flag` is set at the next clock edge. The flag stays set until `ill_clr` is sampled high. A new illegal cycle in the same clock as `ill_clr` wins.
- R6: `nand_ce_n` is the inverse of a register that takes `ce_val` at each clock edge where `ce_wr` is 1. With `ce_wr` at 0, `nand_ce_n` does not change, whether or not the window is being accessed.
- R7: The bridge drives `nand_io` with `bus_wdata` exactly while `nand_we_n` is 0. Otherwise it releases the bus.
- R8: `nand_io` is sampled at every clock edge where a read strobe is active inside the enabled window. At the first edge after the read ends, the last sample is copied to `bus_rdata`.
- R9: `rb_ready` follows `nand_rb` two clock edges after the change. Ready/busy has no effect on any strobe.
- R10: `rb_rise` is high for exactly one cycle, the first cycle in which `rb_ready` is 1 after being 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Enables the NAND logic |
| bus_addr | input | 32 | Bus transfer address |
| bus_rd_n | input | 1 | Bus read strobe, active low |
| bus_wr_n | input | 1 | Bus write strobe, active low |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Byte captured at the end of the last read |
| ce_wr | input | 1 | Write strobe for the chip-enable register |
| ce_val | input | 1 | Value written to the chip-enable register (1 = selected) |
| ill_clr | input | 1 | Clears the sticky illegal-access flag |
| ill_flag | output | 1 | Sticky illegal-access flag |
| rb_ready | output | 1 | Synchronized ready/busy level (1 = ready) |
| rb_rise | output | 1 | One-cycle pulse on busy-to-ready |
| nand_ce_n | output | 1 | Device chip enable, active low |
| nand_cle | output | 1 | Command-latch enable |
| nand_ale | output | 1 | Address-latch enable |
| nand_re_n | output | 1 | Device read enable, active low |
| nand_we_n | output | 1 | Device write enable, active low |
| nand_io | inout | 8 | Device data bus |
| nand_rb | input | 1 | Device ready/busy, asynchronous |

## Verification
The bench goes after the window edges 0x3FFF_FFFF, 0x4000_0000, 0x4FFF_FFFF and 0x5000_0000 while a strobe is held low. A decoder that registered the strobes, or mis-sized the window, would leave a strobe low for one cycle outside it. Offsets with both latch bits set check that CLE and ALE stay low and that the flag sticks, including a set and a clear in the same cycle; a wrong priority would lose the illegal cycle. Back-to-back reads check that the byte is taken from the final read cycle and not from a later bus value. Ready/busy toggles, including single-cycle glitches, check the two-edge latency and that no pulse lasts longer than one cycle.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA
    } acc_state_e;

    typedef enum logic [1:0] {
        CYC_DATA = 2'b00,
        CYC_CMD  = 2'b01,
        CYC_ADDR = 2'b10,
        CYC_BAD  = 2'b11
    } cyc_kind_e;

endpackage

// File: rtl/nand_win_decode.sv
module nand_win_decode
    import nand_bridge_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] WIN_BASE = 32'h4000_0000,
    parameter logic [31:0] WIN_MASK = 32'hF000_0000,
    parameter int          ALE_BIT  = 22,
    parameter int          CLE_BIT  = 21
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output cyc_kind_e         kind
);
    localparam logic [ADDR_W-1:0] BASE_W = WIN_BASE[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] MASK_W = WIN_MASK[ADDR_W-1:0];

    always_comb begin
        hit  = en && ((addr & MASK_W) == BASE_W);
        kind = cyc_kind_e'({addr[ALE_BIT], addr[CLE_BIT]});
    end
endmodule

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_in,
    output logic ready,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              last_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= rb_in;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_d <= 1'b0;
        else        last_d <= chain[LAST];
    end

    assign ready = chain[LAST];
    assign rise  = chain[LAST] & ~last_d;

    // R10: the edge pulse never lasts two cycles
    a_r10_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    // R10: a pulse always comes with the ready level
    a_r10_rise_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> ready);
endmodule

// File: rtl/nand_bus_bridge.sv
module nand_bus_bridge
    import nand_bridge_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 8,
    parameter logic [31:0] WIN_BASE  = 32'h4000_0000,
    parameter logic [31:0] WIN_MASK  = 32'hF000_0000,
    parameter int          ALE_BIT   = 22,
    parameter int          CLE_BIT   = 21,
    parameter int          RB_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ce_wr,
    input  logic              ce_val,
    input  logic              ill_clr,
    output logic              ill_flag,
    output logic              rb_ready,
    output logic              rb_rise,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_re_n,
    output logic              nand_we_n,
    inout  wire  [DATA_W-1:0] nand_io,
    input  logic              nand_rb
);
    logic              win_hit;
    cyc_kind_e         win_kind;
    acc_state_e        acc_q, acc_nxt;
    logic              io_drv;
    logic [DATA_W-1:0] io_last;
    logic [DATA_W-1:0] rdata_q;
    logic              ce_q;
    logic              ill_q;
    logic              rd_live;

    nand_win_decode #(
        .ADDR_W  (ADDR_W),
        .WIN_BASE(WIN_BASE),
        .WIN_MASK(WIN_MASK),
        .ALE_BIT (ALE_BIT),
        .CLE_BIT (CLE_BIT)
    ) i_decode (
        .en  (cfg_en),
        .addr(bus_addr),
        .hit (win_hit),
        .kind(win_kind)
    );

    nand_rb_sync #(.STAGES(RB_STAGES)) i_rb (
        .clk  (clk),
        .rst_n(rst_n),
        .rb_in(nand_rb),
        .ready(rb_ready),
        .rise (rb_rise)
    );

    // Next state: the class of the bus cycle presented now
    always_comb begin
        acc_nxt = ST_IDLE;
        if (rst_n && win_hit) begin
            if (!bus_wr_n) begin
                unique case (win_kind)
                    CYC_CMD:  acc_nxt = ST_CMD;
                    CYC_ADDR: acc_nxt = ST_ADDR;
                    default:  acc_nxt = ST_WDATA;
                endcase
            end else if (!bus_rd_n) begin
                acc_nxt = ST_RDATA;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= ST_IDLE;
        else        acc_q <= acc_nxt;
    end

    // Outputs, taken from the class of the current cycle so that
    // they drop in the same cycle the address leaves the window
    always_comb begin
        nand_we_n = 1'b1;
        nand_re_n = 1'b1;
        io_drv    = 1'b0;
        unique case (acc_nxt)
            ST_IDLE: ;
            ST_CMD, ST_ADDR, ST_WDATA: begin
                nand_we_n = 1'b0;
                io_drv    = 1'b1;
            end
            ST_RDATA: nand_re_n = 1'b0;
            default: ;
        endcase
        nand_cle = rst_n && win_hit && (win_kind == CYC_CMD);
        nand_ale = rst_n && win_hit && (win_kind == CYC_ADDR);
    end

    assign nand_io = io_drv ? bus_wdata : {DATA_W{1'bz}};
    assign rd_live = (acc_nxt == ST_RDATA);

    // Read capture: sample while reading, publish when leaving ST_RDATA
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            io_last <= '0;
            rdata_q <= '0;
        end else begin
            if (rd_live) io_last <= nand_io;
            if (acc_q == ST_RDATA && !rd_live) rdata_q <= io_last;
        end
    end
    assign bus_rdata = rdata_q;

    // Chip-enable register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ce_q <= 1'b0;
        else if (ce_wr) ce_q <= ce_val;
    end
    assign nand_ce_n = ~ce_q;

    // Sticky illegal-access flag: a new illegal cycle wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                        ill_q <= 1'b0;
        else if (acc_nxt != ST_IDLE && win_kind == CYC_BAD) ill_q <= 1'b1;
        else if (ill_clr)                                  ill_q <= 1'b0;
    end
    assign ill_flag = ill_q;

    // R2: no strobe outside the decoded window
    a_r2_no_strobe_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !win_hit |-> (nand_re_n && nand_we_n));
    // R3: a disabled bridge keeps every device pin idle
    a_r3_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> (nand_re_n && nand_we_n && !nand_cle && !nand_ale));
    // R5: the latch enables are never high together
    a_r5_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    // R5: the flag holds until cleared
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ill_flag && !ill_clr) |=> ill_flag);
    // R6: chip enable moves only on a register write
    a_r6_ce_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_wr |=> $stable(nand_ce_n));
    // R7: device is never read and written at once
    a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        nand_re_n || nand_we_n);
endmodule

// File: tb/test_nand_bus_bridge.sv
module test_nand_bus_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0;
    logic [31:0] bus_addr = 32'h0;
    logic        bus_rd_n = 1'b1;
    logic        bus_wr_n = 1'b1;
    logic [7:0]  bus_wdata = 8'h0;
    logic [7:0]  bus_rdata;
    logic        ce_wr = 1'b0;
    logic        ce_val = 1'b0;
    logic        ill_clr = 1'b0;
    logic        ill_flag, rb_ready, rb_rise;
    logic        nand_ce_n, nand_cle, nand_ale, nand_re_n, nand_we_n;
    logic        nand_rb = 1'b0;
    logic [7:0]  dev_byte = 8'h00;
    wire  [7:0]  io_bus;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Device side: answers only while the bus reads
    assign io_bus = (!bus_rd_n) ? dev_byte : 8'bz;

    always #2 clk = ~clk;

    nand_bus_bridge i_nand_bus_bridge (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .bus_addr(bus_addr),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ce_wr(ce_wr), .ce_val(ce_val),
        .ill_clr(ill_clr), .ill_flag(ill_flag), .rb_ready(rb_ready),
        .rb_rise(rb_rise), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_re_n(nand_re_n), .nand_we_n(nand_we_n),
        .nand_io(io_bus), .nand_rb(nand_rb)
    );

    // Reference model
    bit       m_ce, m_ill, m_rd_prev, s1, s2, s3;
    bit [7:0] m_last, m_rdata;

    function automatic bit in_win();
        return rst_n && cfg_en && (bus_addr[31:28] == 4'h4);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ce <= 0; m_ill <= 0; m_rd_prev <= 0; m_last <= 0; m_rdata <= 0;
            s1 <= 0; s2 <= 0; s3 <= 0;
        end else begin
            automatic bit rd_now = in_win() && !bus_rd_n && bus_wr_n;
            automatic bit acc    = in_win() && (!bus_rd_n || !bus_wr_n);
            if (ce_wr) m_ce <= ce_val;
            if (acc && bus_addr[21] && bus_addr[22]) m_ill <= 1;
            else if (ill_clr) m_ill <= 0;
            if (rd_now) m_last <= io_bus;
            if (m_rd_prev && !rd_now) m_rdata <= m_last;
            m_rd_prev <= rd_now;
            s1 <= nand_rb; s2 <= s1; s3 <= s2;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    // Compare every output away from the active edge
    always @(negedge clk) if (!done) begin
        automatic bit w   = in_win();
        automatic bit b21 = bus_addr[21];
        automatic bit b22 = bus_addr[22];
        automatic bit ewe = !(w && !bus_wr_n);
        automatic bit ere = !(w && !bus_rd_n && bus_wr_n);
        chk(nand_we_n === ewe, "R2 R3 we_n", nand_we_n, ewe);
        chk(nand_re_n === ere, "R2 R3 re_n", nand_re_n, ere);
        chk(nand_cle === (w && b21 && !b22), "R4 R5 cle", nand_cle, w && b21 && !b22);
        chk(nand_ale === (w && b22 && !b21), "R4 R5 ale", nand_ale, w && b22 && !b21);
        chk(nand_ce_n === !m_ce, "R1 R6 ce_n", nand_ce_n, !m_ce);
        chk(ill_flag === m_ill, "R1 R5 ill_flag", ill_flag, m_ill);
        chk(rb_ready === s2, "R1 R9 rb_ready", rb_ready, s2);
        chk(rb_rise === (s2 && !s3), "R10 rb_rise", rb_rise, s2 && !s3);
        chk(bus_rdata === m_rdata, "R1 R8 rdata", bus_rdata, m_rdata);
        if (!ewe) chk(io_bus === bus_wdata, "R7 io drive", io_bus, bus_wdata);
    end

    task automatic cyc(input logic [31:0] a, input bit rd, input bit wr, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_rd_n = !rd; bus_wr_n = !wr; bus_wdata = d;
        dev_byte = d ^ 8'h5A;
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state observed while reset is held
        nand_rb = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R3: disabled bridge, window accesses of every kind
        cyc(32'h4020_0000, 0, 1, 8'h11);
        cyc(32'h4040_0000, 1, 0, 8'h12);
        cyc(32'h4060_0000, 0, 1, 8'h13);
        #0 cfg_en = 1'b1;
        // R4: command, address, data writes
        cyc(32'h4020_0000, 0, 1, 8'hFF);
        cyc(32'h4040_0000, 0, 1, 8'h00);
        cyc(32'h4000_0000, 0, 1, 8'hA5);
        // R2: strobe held while address crosses the window edges
        cyc(32'h3FFF_FFFF, 0, 1, 8'h21);
        cyc(32'h4000_0000, 0, 1, 8'h22);
        cyc(32'h4FFF_FFFF, 1, 0, 8'h23);
        cyc(32'h5000_0000, 1, 0, 8'h24);
        cyc(32'h4000_0010, 1, 0, 8'h25);
        // R8: back-to-back reads then idle
        cyc(32'h4000_0000, 1, 0, 8'h30);
        cyc(32'h4000_0000, 1, 0, 8'h31);
        cyc(32'h4000_0000, 0, 0, 8'h32);
        cyc(32'h4000_0000, 0, 0, 8'h33);
        // R5: illegal cycle, clear, set and clear together
        cyc(32'h4060_0000, 0, 1, 8'h40);
        cyc(32'h0000_0000, 0, 0, 8'h00);
        ill_clr = 1'b1;
        cyc(32'h0000_0000, 0, 0, 8'h00);
        cyc(32'h4060_0000, 1, 0, 8'h41);
        ill_clr = 1'b0;
        cyc(32'h0000_0000, 0, 0, 8'h00);
        // R6: chip enable persists outside the window
        ce_wr = 1'b1; ce_val = 1'b1;
        cyc(32'h1000_0000, 0, 0, 8'h00);
        ce_wr = 1'b0;
        cyc(32'h1000_0000, 0, 0, 8'h00);
        cyc(32'h4000_0000, 0, 1, 8'h50);
        // R9 R10: ready/busy glitch and edges
        nand_rb = 1'b0; cyc(32'h0, 0, 0, 0); cyc(32'h0, 0, 0, 0);
        nand_rb = 1'b1; cyc(32'h0, 0, 0, 0);
        nand_rb = 1'b0; cyc(32'h0, 0, 0, 0);
        nand_rb = 1'b1; cyc(32'h0, 0, 0, 0); cyc(32'h0, 0, 0, 0);
        // Mixed pattern
        for (int i = 0; i < 3000; i++) begin
            automatic int unsigned r = $urandom;
            automatic logic [31:0] a;
            case (r[2:0])
                3'd0:    a = 32'h3FFF_FFFF;
                3'd1:    a = 32'h5000_0000;
                default: a = {4'h4, 5'd0, r[4:3], r[27:7]};
            endcase
            cfg_en  = (r[31:28] != 4'h0);
            ce_wr   = (r[12:10] == 3'd0);
            ce_val  = r[13];
            ill_clr = (r[16:14] == 3'd0);
            if (r[20:18] == 3'd0) nand_rb = ~nand_rb;
            if (r[6:5] == 2'd0)      cyc(a, 0, 0, r[24:17]);
            else if (r[6:5] == 2'd1) cyc(a, 1, 0, r[24:17]);
            else                     cyc(a, 0, 1, r[24:17]);
        end
        cyc(32'h0, 0, 0, 0);
        @(posedge clk);
        @(negedge clk);
        #1 done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule